// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Boundary-Committed Updates

This block holds several independent pulse-width channels behind a small memory-mapped write/read port. Each channel has four programmable values: a prescale divider, a period modulus, a high-time count and a run bit. Software writes the prescale, modulus and high-time values into staging registers. A write to the high-time register then commits all three staged values as one set.

While a channel is running, a committed set waits until the current period has finished. The next period starts with the new values, so no period is built from a mixture of old and new settings. A channel that is stopped, or whose active modulus is zero, has no period in progress, so a commit takes effect at once. Clearing the run bit stops the output in the next cycle and does not finish the period. Setting the run bit again starts a fresh period from count zero.

The output is high at the start of each period. It is high for (prescale+1)·duty clock cycles out of a period of (prescale+1)·modulus cycles.

Top module: `pwm_bank`

## Requirements
- R1: Channel c's registers occupy the 32-byte bank starting at c·32. Within a bank, offset 0x00 holds the prescale (8 bits), 0x04 the modulus (8 bits), 0x08 the duty (16 bits) and 0x18 the run bit (bit 0). Read data appears one cycle after the address. Bits above each field, and every unmapped offset, read as zero.
- R2: A read returns the staged value last written to that register, or the current run bit. A write to one channel leaves every other channel's registers unchanged.
- R3: With modulus M>0, prescale P and duty D<M, the output repeats every (P+1)·M cycles and is high for the first (P+1)·D cycles of each period.
- R4: When the active duty is greater than or equal to the active modulus, and the modulus is nonzero, the output stays high for as long as the channel runs.
- R5: When the active duty is zero, the output stays low.
- R6: When the active modulus is zero, the output stays low and the channel does not count.
- R7: Writes to the prescale or modulus register alone do not change the output waveform. Only a duty write commits the staged values.
- R8: A commit made while the channel runs with a nonzero modulus takes effect at the next period boundary. The rest of the current period keeps the old waveform.
- R9: A commit made while the channel is stopped takes effect at once, so the next start uses it.
- R10: Writing 0 to the run bit drives the output low in the cycle after the write, even in the middle of a high phase.
- R11: Writing 1 to the run bit of a stopped channel starts a new period from its beginning. The output is high in the cycle after the write whenever the duty is nonzero.
- R12: During and after reset, the outputs are low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 7 | Byte address (channel in the top bits, register offset in the low five) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pwm_out | output | 4 | Registered pulse outputs, one per channel |

## Verification
The bench commits a new set partway through a running period and checks the output cycle by cycle on both sides of the boundary. A design that applies the set at once would show the new waveform early, and one that never applies it would keep the old one. It stops a channel during its high phase and expects a low output in the very next cycle, which catches a design that waits for the period to end. It also restarts a channel and expects the period to begin again from its start. Writes to prescale or modulus without a duty write must leave the waveform unchanged, which catches a commit on the wrong register. Extreme values are tested too: duty at or above the modulus, duty zero and modulus zero, where a comparator off by one would give a stray pulse or a missing pulse. Random configurations then check the high-cycle count over whole periods.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int BANK_SHIFT = 5;
  typedef enum logic [BANK_SHIFT-1:0] {
    OFS_PRESCALE = 5'h00,
    OFS_MODULUS  = 5'h04,
    OFS_DUTY     = 5'h08,
    OFS_RUN      = 5'h18
  } reg_ofs_e;
endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = $clog2(NCH) + BANK_SHIFT
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    sel_pre,
  output logic [NCH-1:0]    sel_mod,
  output logic [NCH-1:0]    sel_duty,
  output logic [NCH-1:0]    sel_run
);
  localparam int CH_W = ADDR_W - BANK_SHIFT;

  logic [CH_W-1:0]       ch;
  logic [BANK_SHIFT-1:0] ofs;

  assign ch  = addr[ADDR_W-1:BANK_SHIFT];
  assign ofs = addr[BANK_SHIFT-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    logic hit;
    assign hit         = wr && (ch == CH_W'(c));
    assign sel_pre[c]  = hit && (ofs == OFS_PRESCALE);
    assign sel_mod[c]  = hit && (ofs == OFS_MODULUS);
    assign sel_duty[c] = hit && (ofs == OFS_DUTY);
    assign sel_run[c]  = hit && (ofs == OFS_RUN);
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_pre,
  input  logic              wr_mod,
  input  logic              wr_duty,
  input  logic              wr_run,
  input  logic [DUTY_W-1:0] wdata,
  output logic [PRE_W-1:0]  stg_pre,
  output logic [MOD_W-1:0]  stg_mod,
  output logic [DUTY_W-1:0] stg_duty,
  output logic              running,
  output logic              pwm
);
  // staging, pending commit, active set, counters
  logic [PRE_W-1:0]  act_pre,  act_pre_n;
  logic [MOD_W-1:0]  act_mod,  act_mod_n;
  logic [DUTY_W-1:0] act_duty, act_duty_n;
  logic              pend,     pend_n;
  logic              run_n;
  logic [PRE_W-1:0]  pcnt,     pcnt_n;
  logic [MOD_W-1:0]  ccnt,     ccnt_n;
  logic              pwm_n;
  logic              start, boundary, apply;

  always_comb begin
    run_n    = wr_run ? wdata[0] : running;
    start    = wr_run && wdata[0] && !running;
    boundary = running && (act_mod != '0) && (pcnt == act_pre)
               && (ccnt == act_mod - MOD_W'(1));
    apply    = pend && (!running || (act_mod == '0) || boundary);

    act_pre_n  = apply ? stg_pre  : act_pre;
    act_mod_n  = apply ? stg_mod  : act_mod;
    act_duty_n = apply ? stg_duty : act_duty;
    pend_n     = wr_duty ? 1'b1 : (apply ? 1'b0 : pend);

    pcnt_n = '0;
    ccnt_n = '0;
    if (run_n && !start && (act_mod != '0) && !boundary) begin
      if (pcnt == act_pre) begin
        ccnt_n = ccnt + MOD_W'(1);
      end else begin
        pcnt_n = pcnt + PRE_W'(1);
        ccnt_n = ccnt;
      end
    end

    pwm_n = run_n && (act_mod_n != '0) && (act_duty_n != '0) &&
            ((act_duty_n >= DUTY_W'(act_mod_n)) || (DUTY_W'(ccnt_n) < act_duty_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_pre  <= '0;
      stg_mod  <= '0;
      stg_duty <= '0;
      running  <= 1'b0;
      pend     <= 1'b0;
      act_pre  <= '0;
      act_mod  <= '0;
      act_duty <= '0;
      pcnt     <= '0;
      ccnt     <= '0;
      pwm      <= 1'b0;
    end else begin
      if (wr_pre)  stg_pre  <= wdata[PRE_W-1:0];
      if (wr_mod)  stg_mod  <= wdata[MOD_W-1:0];
      if (wr_duty) stg_duty <= wdata;
      running  <= run_n;
      pend     <= pend_n;
      act_pre  <= act_pre_n;
      act_mod  <= act_mod_n;
      act_duty <= act_duty_n;
      pcnt     <= pcnt_n;
      ccnt     <= ccnt_n;
      pwm      <= pwm_n;
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(NCH) + BANK_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int CH_W = ADDR_W - BANK_SHIFT;

  logic [NCH-1:0]    sel_pre, sel_mod, sel_duty, sel_run;
  logic [PRE_W-1:0]  stg_pre  [NCH];
  logic [MOD_W-1:0]  stg_mod  [NCH];
  logic [DUTY_W-1:0] stg_duty [NCH];
  logic [NCH-1:0]    running;
  logic [DATA_W-1:0] rd_val;
  logic [CH_W-1:0]   rd_ch;

  pwm_bank_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .wr(bus_wr), .addr(bus_addr),
    .sel_pre(sel_pre), .sel_mod(sel_mod), .sel_duty(sel_duty), .sel_run(sel_run)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_bank_chan #(.PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_pre(sel_pre[c]), .wr_mod(sel_mod[c]),
      .wr_duty(sel_duty[c]), .wr_run(sel_run[c]),
      .wdata(bus_wdata[DUTY_W-1:0]),
      .stg_pre(stg_pre[c]), .stg_mod(stg_mod[c]), .stg_duty(stg_duty[c]),
      .running(running[c]), .pwm(pwm_out[c])
    );
  end

  assign rd_ch = bus_addr[ADDR_W-1:BANK_SHIFT];

  always_comb begin
    rd_val = '0;
    case (bus_addr[BANK_SHIFT-1:0])
      OFS_PRESCALE: rd_val = DATA_W'(stg_pre[rd_ch]);
      OFS_MODULUS:  rd_val = DATA_W'(stg_mod[rd_ch]);
      OFS_DUTY:     rd_val = DATA_W'(stg_duty[rd_ch]);
      OFS_RUN:      rd_val = DATA_W'(running[rd_ch]);
      default:      rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_val;
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH    = 4,
  parameter int PRE_W  = 8,
  parameter int DUTY_W = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCH-1:0]    pwm_out
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pwm_out == '0) && (bus_rdata == '0)); // R12

  AST_STOP_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[4:0] == 5'h18 && !bus_wdata[0])
      |=> !pwm_out[$past(bus_addr[ADDR_W-1:5])]); // R10

  AST_PRE_FIELD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[4:0] == 5'h00) |=> (bus_rdata[DATA_W-1:PRE_W] == '0)); // R1

  AST_DUTY_FIELD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[4:0] == 5'h08) |=> (bus_rdata[DATA_W-1:DUTY_W] == '0)); // R1

  AST_RUN_FIELD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[4:0] == 5'h18) |=> (bus_rdata[DATA_W-1:1] == '0)); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[4:0] == 5'h0C) |=> (bus_rdata == '0)); // R1
endmodule

bind pwm_bank pwm_bank_chk #(
  .NCH(NCH), .PRE_W(PRE_W), .DUTY_W(DUTY_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int NCH = 4;
  localparam int AW  = 7;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  pwm_bank u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nerr = nerr + 1;
      nchk = nchk + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr_reg(input int ch, input int ofs, input int val);
    bus_wr    = 1'b1;
    bus_addr  = AW'(ch * 32 + ofs);
    bus_wdata = DW'(val);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int ch, input int ofs, output int val);
    bus_addr = AW'(ch * 32 + ofs);
    @(posedge clk);
    @(negedge clk);
    val = int'(bus_rdata);
  endtask

  task automatic cfg(input int ch, input int pre, input int md, input int dt);
    wr_reg(ch, 'h00, pre);
    wr_reg(ch, 'h04, md);
    wr_reg(ch, 'h08, dt);
  endtask

  task automatic count_high(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[ch]) cnt++;
      @(negedge clk);
    end
  endtask

  function automatic int exp_high(input int pre, input int md, input int dt, input int nper);
    if (md == 0 || dt == 0) return 0;
    return nper * (pre + 1) * ((dt >= md) ? md : dt);
  endfunction

  initial begin
    int v, cnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R12 outputs low in reset", int'(pwm_out), 0);
    rst = 1'b0;
    @(negedge clk);
    rd_reg(1, 'h08, v); check("R12 duty reads zero", v, 0);
    rd_reg(3, 'h18, v); check("R12 run bit reads zero", v, 0);

    // R1 / R2 register map and readback
    wr_reg(2, 'h00, 'h1A5);
    wr_reg(2, 'h04, 'h3C);
    wr_reg(2, 'h08, 'hBEEF1);
    wr_reg(3, 'h00, 'h77);
    rd_reg(2, 'h00, v); check("R1 prescale 8-bit field", v, 'hA5);
    rd_reg(2, 'h04, v); check("R2 modulus readback", v, 'h3C);
    rd_reg(2, 'h08, v); check("R1 duty 16-bit field", v, 'hEEF1);
    rd_reg(2, 'h0C, v); check("R1 unmapped offset", v, 0);
    rd_reg(3, 'h00, v); check("R2 other channel prescale", v, 'h77);
    rd_reg(1, 'h00, v); check("R2 untouched channel", v, 0);

    // R9 + R3 + R11: commit while stopped, start, count
    cfg(0, 1, 4, 1);
    wr_reg(0, 'h18, 1);
    rd_reg(0, 'h18, v); check("R2 run bit readback", v, 1);
    wr_reg(0, 'h18, 0);
    wr_reg(0, 'h18, 1);
    check("R11 high right after start", int'(pwm_out[0]), 1);
    count_high(0, 32, cnt); check("R3 high cycles over 4 periods", cnt, 8);

    // R8: commit mid-period, boundary switch
    wr_reg(0, 'h18, 0);
    wr_reg(0, 'h18, 1);          // index 0 now
    check("R3 idx0 high", int'(pwm_out[0]), 1);
    @(negedge clk);
    check("R3 idx1 high", int'(pwm_out[0]), 1);
    @(negedge clk);              // idx2
    wr_reg(0, 'h04, 4);          // idx3
    wr_reg(0, 'h08, 4);          // idx4
    cnt = 0;
    for (int i = 4; i < 8; i++) begin
      if (pwm_out[0]) cnt++;
      @(negedge clk);
    end
    check("R8 old waveform kept to period end", cnt, 0);
    count_high(0, 8, cnt); check("R8 new waveform from boundary", cnt, 8);

    // R10: stop during high
    wr_reg(0, 'h18, 0);
    check("R10 low at once after stop", int'(pwm_out[0]), 0);
    count_high(0, 10, cnt); check("R10 stays low", cnt, 0);

    // R4 duty >= modulus
    cfg(1, 0, 5, 7);
    wr_reg(1, 'h18, 1);
    count_high(1, 20, cnt); check("R4 duty above modulus high", cnt, 20);
    cfg(1, 2, 6, 6);
    count_high(1, 30, cnt); check("R4 duty equals modulus high", cnt, 30);

    // R5 duty zero
    cfg(1, 0, 5, 0);
    repeat (20) @(negedge clk);
    count_high(1, 20, cnt); check("R5 zero duty low", cnt, 0);
    wr_reg(1, 'h18, 0);

    // R6 modulus zero
    cfg(2, 0, 0, 5);
    wr_reg(2, 'h18, 1);
    count_high(2, 20, cnt); check("R6 zero modulus low", cnt, 0);
    cfg(2, 0, 4, 2);             // commit while modulus zero -> at once (R9)
    count_high(2, 8, cnt); check("R9 commit with zero modulus", cnt, 4);
    wr_reg(2, 'h18, 0);

    // R7: prescale/modulus writes alone do nothing
    cfg(0, 0, 10, 3);            // stopped: applies now
    wr_reg(0, 'h18, 1);
    wr_reg(0, 'h00, 3);
    wr_reg(0, 'h04, 5);
    wr_reg(0, 'h18, 0);
    wr_reg(0, 'h18, 1);
    count_high(0, 20, cnt); check("R7 no commit without duty write", cnt, 6);
    wr_reg(0, 'h18, 0);

    // R11 restart mid-period
    cfg(0, 0, 10, 3);
    wr_reg(0, 'h18, 1);
    repeat (5) @(negedge clk);
    wr_reg(0, 'h18, 0);
    wr_reg(0, 'h18, 1);
    count_high(0, 3, cnt); check("R11 restart high phase", cnt, 3);
    check("R11 restart falls after duty", int'(pwm_out[0]), 0);
    wr_reg(0, 'h18, 0);

    // random configurations (R3/R4/R5)
    for (int k = 0; k < 8; k++) begin
      int ch, pre, md, dt;
      ch  = int'($urandom % 4);
      pre = int'($urandom % 3);
      md  = 1 + int'($urandom % 12);
      dt  = int'($urandom % 15);
      wr_reg(ch, 'h18, 0);
      cfg(ch, pre, md, dt);
      wr_reg(ch, 'h18, 1);
      count_high(ch, 2 * (pre + 1) * md, cnt);
      check("R3 random config high count", cnt, exp_high(pre, md, dt, 2));
      wr_reg(ch, 'h18, 0);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule